// File: doc/BRIEF.md
# Byte-Serial Up/Down Counter Channel

This block is one channel of a 24-bit up/down event counter that a host reaches through two byte-wide ports. The data port carries the wide values one byte at a time. The control port takes reset and transfer commands on writes and returns a status flag byte on reads. An internal byte pointer picks which byte a data access touches and advances after each access. A host therefore resets the pointer, then writes or reads three bytes, least significant first.

The host cannot write the counter directly. It first fills a preset register through the data port, then issues a command that copies the preset into the counter. To read the count, it issues a command that freezes the live count in an output latch, then reads the latch back byte by byte. The counter steps on single-cycle count-up and count-down strobes. It wraps at both ends, and every wrap toggles a flag. A noise-filter prescaler byte is loaded from the first preset byte and is driven out for a neighbouring input filter.

Top module: `byteser_count_chan`

## Requirements
- R1: After reset the count, preset, output latch, byte pointer, prescaler output and all flags are zero. A control-port read returns 0x00.
- R2: A control write whose top two bits are 00 and whose bit 0 is set returns the byte pointer to the least significant byte.
- R3: Data-port writes fill the preset register least significant byte first. After the third access the pointer saturates, and further data writes change nothing until the pointer is reset.
- R4: A control command with bit 1 copies the live count into the output latch. Data-port reads then return it least significant byte first, and a read past the third byte returns 0x00. Bits 0 and 1 may be combined in one write.
- R5: A control command with bit 2 copies the preset register into the counter. Data-port writes never change the count.
- R6: Counting up from 0xFFFFFF gives 0, toggles the carry flag (bit 1) and clears the sign flag (bit 3). Counting down from 0 gives 0xFFFFFF, toggles the borrow flag (bit 0) and sets the sign flag.
- R7: Flag bit 5 reads 1 after the last step went up and 0 after it went down.
- R8: When up and down strobes arrive in the same cycle, the count is unchanged and the error flag (bit 4) is set.
- R9: A control command with bit 3 clears flag bits 0 to 3 and leaves the error flag. A command with bit 4 clears the error flag.
- R10: A control command with bit 5 loads the prescaler output from preset byte 0. It may be combined with bit 0 in one write.
- R11: A control write whose top two bits are not 00 has no effect on this channel.
- R12: The compare flag (bit 2) is set when a count step lands on a value equal to the preset register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the selected port |
| rd_en | input | 1 | Read strobe; advances the pointer on a data read |
| port_sel | input | 1 | 0 selects the data port, 1 selects the control port |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Latch byte at the pointer, or the flag byte |
| cnt_up | input | 1 | Count-up strobe |
| cnt_dn | input | 1 | Count-down strobe |
| prescale | output | 8 | Loaded filter prescaler value |

## Verification
A wrong byte pointer shows up at once as bytes in the wrong order, or as a repeated or missing byte, on the very next data access. A corrupted preset or count stays hidden until a transfer-to-counter or a latch command and the three reads after it, so every scenario ends with a latch-and-read. Flag faults show on the control read in the cycle after the step that caused them. For that reason the bench reads the flags right after each wrap, each noise event and each clear.

// File: rtl/byteser_pkg.sv
package byteser_pkg;
   localparam int unsigned BYTE_W = 8;

   // control-word action bit positions (register select 00)
   localparam int unsigned ACT_PTR_RST  = 0;
   localparam int unsigned ACT_LATCH    = 1;
   localparam int unsigned ACT_LOAD     = 2;
   localparam int unsigned ACT_CLR_FLG  = 3;
   localparam int unsigned ACT_CLR_ERR  = 4;
   localparam int unsigned ACT_PRESCALE = 5;

   typedef struct packed {
      logic [1:0] pad;
      logic       dir_up;
      logic       err;
      logic       sign;
      logic       cmp;
      logic       carry;
      logic       borrow;
   } flag_byte_t;
endpackage

// File: rtl/bsc_byte_port.sv
module bsc_byte_port #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned NBYTES = 3,
   localparam int unsigned CNT_W = BYTE_W * NBYTES,
   localparam int unsigned PTR_W = $clog2(NBYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic              data_rd,
   input  logic              ptr_rst,
   input  logic              latch_en,
   input  logic [BYTE_W-1:0] wdata,
   input  logic [CNT_W-1:0]  count_in,
   output logic [CNT_W-1:0]  preset,
   output logic [BYTE_W-1:0] data_out
);
   localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NBYTES);

   logic [PTR_W-1:0] ptr;
   logic [CNT_W-1:0] latch_q;
   logic             at_end;

   assign at_end = (ptr == PTR_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ptr <= '0;
      else if (ptr_rst)                         ptr <= '0;
      else if ((data_wr || data_rd) && !at_end) ptr <= ptr + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        latch_q <= '0;
      else if (latch_en) latch_q <= count_in;
   end

   for (genvar g = 0; g < NBYTES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            preset[g*BYTE_W +: BYTE_W] <= '0;
         else if (data_wr && ptr == PTR_W'(g))
            preset[g*BYTE_W +: BYTE_W] <= wdata;
      end
   end

   always_comb begin
      data_out = '0;
      for (int i = 0; i < NBYTES; i++)
         if (ptr == PTR_W'(i)) data_out = latch_q[i*BYTE_W +: BYTE_W];
   end

   a_r2_ptr_reset: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_rst |=> ptr == '0);
   a_r3_ptr_sat: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= PTR_END);
   a_r3_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (at_end && !ptr_rst) |=> $stable(preset) && at_end);
endmodule

// File: rtl/bsc_count_core.sv
module bsc_count_core
   import byteser_pkg::*;
#(
   parameter int unsigned CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             up,
   input  logic             dn,
   input  logic             load,
   input  logic             clr_flags,
   input  logic             clr_err,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] count,
   output flag_byte_t       flags
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             step_up, step_dn;
   logic [CNT_W-1:0] nxt;

   assign step_up = up && !dn;
   assign step_dn = dn && !up;
   assign nxt     = step_up ? count + 1'b1 : count - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   count <= '0;
      else if (load)                count <= preset;
      else if (step_up || step_dn)  count <= nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         if (step_up) flags.dir_up <= 1'b1;
         if (step_dn) flags.dir_up <= 1'b0;
         if (clr_err)       flags.err <= 1'b0;
         else if (up && dn) flags.err <= 1'b1;
         if (clr_flags) begin
            flags.borrow <= 1'b0;
            flags.carry  <= 1'b0;
            flags.cmp    <= 1'b0;
            flags.sign   <= 1'b0;
         end else if (!load && (step_up || step_dn)) begin
            if (step_up && count == CNT_MAX) begin
               flags.carry <= ~flags.carry;
               flags.sign  <= 1'b0;
            end
            if (step_dn && count == '0) begin
               flags.borrow <= ~flags.borrow;
               flags.sign   <= 1'b1;
            end
            if (nxt == preset) flags.cmp <= 1'b1;
         end
      end
   end

   a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> count == $past(preset));
   a_r8_noise_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (up && dn && !load) |=> $stable(count) && flags.err);
   a_r6_up_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step_up && !load && count == CNT_MAX) |=> count == '0);
   a_r6_dn_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step_dn && !load && count == '0) |=> count == CNT_MAX);
   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_flags |=> (flags.borrow | flags.carry | flags.cmp | flags.sign) == 1'b0);
endmodule

// File: rtl/byteser_count_chan.sv
module byteser_count_chan
   import byteser_pkg::*;
#(
   parameter int unsigned NBYTES = 3,
   localparam int unsigned CNT_W = BYTE_W * NBYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              port_sel,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic              cnt_up,
   input  logic              cnt_dn,
   output logic [BYTE_W-1:0] prescale
);
   initial begin
      if (NBYTES < 1 || NBYTES > 8)
         $error("byteser_count_chan: NBYTES must lie in 1..8");
   end

   logic              cmd_ok;
   logic [5:0]        act;
   logic [CNT_W-1:0]  preset, count;
   logic [BYTE_W-1:0] data_out;
   flag_byte_t        flags;

   assign cmd_ok = wr_en && port_sel && (wdata[7:6] == 2'b00);
   assign act    = cmd_ok ? wdata[5:0] : 6'd0;

   bsc_byte_port #(.BYTE_W(BYTE_W), .NBYTES(NBYTES)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .data_wr  (wr_en && !port_sel),
      .data_rd  (rd_en && !port_sel),
      .ptr_rst  (act[ACT_PTR_RST]),
      .latch_en (act[ACT_LATCH]),
      .wdata    (wdata),
      .count_in (count),
      .preset   (preset),
      .data_out (data_out)
   );

   bsc_count_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .up        (cnt_up),
      .dn        (cnt_dn),
      .load      (act[ACT_LOAD]),
      .clr_flags (act[ACT_CLR_FLG]),
      .clr_err   (act[ACT_CLR_ERR]),
      .preset    (preset),
      .count     (count),
      .flags     (flags)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   prescale <= '0;
      else if (act[ACT_PRESCALE])   prescale <= preset[BYTE_W-1:0];
   end

   assign rdata = port_sel ? flags : data_out;

   a_r11_foreign_select: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && port_sel && wdata[7:6] != 2'b00 && !cnt_up && !cnt_dn)
      |=> $stable(count) && $stable(prescale));
   a_r10_prescale: assert property (@(posedge clk) disable iff (!rst_n)
      act[ACT_PRESCALE] |=> prescale == $past(preset[BYTE_W-1:0]));
endmodule

// File: tb/test_byteser_count_chan.sv
`timescale 1ns/100ps
module test_byteser_count_chan;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, port_sel = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, prescale;
   logic       cnt_up = 1'b0, cnt_dn = 1'b0;
   int         checks = 0, errors = 0, cycles = 0;

   always #2.5 clk = ~clk;

   byteser_count_chan i_byteser_count_chan (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
      .port_sel(port_sel), .wdata(wdata), .rdata(rdata),
      .cnt_up(cnt_up), .cnt_dn(cnt_dn), .prescale(prescale));

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic ctrl_wr(logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; port_sel = 1'b1; wdata = b;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic data_wr(logic [7:0] b);
      @(negedge clk); wr_en = 1'b1; port_sel = 1'b0; wdata = b;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic data_rd(output logic [7:0] b);
      @(negedge clk); port_sel = 1'b0; #1 b = rdata; rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
   endtask

   task automatic flags_rd(output logic [7:0] b);
      @(negedge clk); port_sel = 1'b1; #1 b = rdata;
   endtask

   task automatic step(logic u, logic d, int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk); cnt_up = u; cnt_dn = d;
      end
      @(negedge clk); cnt_up = 1'b0; cnt_dn = 1'b0;
   endtask

   task automatic set_preset(logic [23:0] v);
      ctrl_wr(8'h01);
      data_wr(v[7:0]); data_wr(v[15:8]); data_wr(v[23:16]);
   endtask

   task automatic read_count(string req, logic [23:0] exp);
      logic [7:0] b;
      ctrl_wr(8'h03);   // latch count and reset pointer in one write
      for (int i = 0; i < 3; i++) begin
         data_rd(b);
         chk(req, b, exp[i*8 +: 8]);
      end
   endtask

   task automatic t_reset;
      logic [7:0] b;
      flags_rd(b);      chk("R1 flags", b, 8'h00);
      chk("R1 prescale", prescale, 8'h00);
      @(negedge clk); port_sel = 1'b0; #1 chk("R1 data", rdata, 8'h00);
   endtask

   task automatic t_preset_and_latch;
      logic [7:0] b;
      set_preset(24'h123456);
      data_wr(8'hAA);            // R3: saturated pointer, ignored
      read_count("R5 no direct write", 24'h000000);
      ctrl_wr(8'h04);            // R5: load preset
      read_count("R4 R3 byte order", 24'h123456);
      data_rd(b); chk("R4 read past end", b, 8'h00);
      ctrl_wr(8'h01);            // R2: pointer back to byte 0
      data_rd(b); chk("R2 pointer reset", b, 8'h56);
      flags_rd(b); chk("R5 load keeps flags", b, 8'h00);
   endtask

   task automatic t_foreign_select;
      set_preset(24'h000001);
      ctrl_wr(8'h44);            // select 01: must not load
      read_count("R11 ignored", 24'h123456);
      ctrl_wr(8'hA0);            // select 10: must not touch prescaler
      chk("R11 prescale", prescale, 8'h00);
      ctrl_wr(8'h04);
      read_count("R5 load", 24'h000001);
   endtask

   task automatic t_count_up_and_noise;
      logic [7:0] b;
      step(1'b1, 1'b0, 3);
      read_count("R7 up count", 24'h000004);
      flags_rd(b); chk("R7 dir up", b, 8'h20);
      step(1'b1, 1'b1, 1);
      flags_rd(b); chk("R8 error", b, 8'h30);
      read_count("R8 count held", 24'h000004);
      ctrl_wr(8'h08);
      flags_rd(b); chk("R9 clr keeps err", b, 8'h30);
      ctrl_wr(8'h10);
      flags_rd(b); chk("R9 clr err", b, 8'h20);
   endtask

   task automatic t_wraps;
      logic [7:0] b;
      set_preset(24'hFFFFFE);
      ctrl_wr(8'h04);
      step(1'b1, 1'b0, 2);
      read_count("R6 up wrap", 24'h000000);
      flags_rd(b); chk("R6 carry", b, 8'h22);
      step(1'b0, 1'b1, 1);
      read_count("R6 down wrap", 24'hFFFFFF);
      flags_rd(b); chk("R6 borrow sign", b, 8'h0B);
      step(1'b0, 1'b1, 1);
      flags_rd(b); chk("R12 compare", b, 8'h0F);
      ctrl_wr(8'h08);
      flags_rd(b); chk("R9 clear", b, 8'h00);
   endtask

   task automatic t_prescale;
      ctrl_wr(8'h01);
      data_wr(8'h5A);
      ctrl_wr(8'h21);
      @(negedge clk); chk("R10 prescale", prescale, 8'h5A);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_preset_and_latch();
      t_foreign_select();
      t_count_up_and_noise();
      t_wraps();
      t_prescale();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule